// File: doc/BRIEF.md
# Floppy Interface Control Register with Wait-State Handshake

This block sits on a simple processor I/O bus next to a floppy disk controller. Software writes one byte to a fixed I/O port. The block decodes that port from the low address bits and the write strobe. It captures the byte when the combined write enable ends, and it holds the byte until the next such write or a reset. The stored bits drive the rest of the interface. They produce a one-hot select for one of four drives, the media-size line, a timing-mode line for the controller, the density line, and a write-precompensation enable. The precompensation enable also depends on the current track number.

One bit of the byte arms a wait-state handshake. When it is set, each new access to the controller's data register pulls the bus ready line low, which stalls the processor. Ready is released in the cycle in which the controller raises its data request. The CPU can then move each byte exactly when the controller is able to accept or supply it.

Top module: `fdc_ifctl`

## Requirements
- R1: The register loads only when a write strobe coincides with address bits [2:0] = 3'b101 (A0=1, A1=0, A2=1). The byte present while that enable was high is committed in the clock cycle after the enable falls. Writes to any other address leave every output unchanged.
- R2: An active-high reset clears the register to 8'h00. As a result no drive is selected, media is 5.25-inch, the timing mode is 5.25-inch, double density is selected, precompensation is on, and ready is high.
- R3: With bit 3 = 1, the select output drv_sel is one-hot and indexes drive (bit0*2 + bit1). So (bit0,bit1) = 00 gives drv_sel[0], 01 gives drv_sel[1], 10 gives drv_sel[2] and 11 gives drv_sel[3].
- R4: With bit 3 = 0, all drv_sel bits are 0 whatever bits 0 and 1 hold.
- R5: media_8in equals bit 2 (1 = 8-inch, 0 = 5.25-inch).
- R6: ctl_8in_mode is 1 when bit 5 or bit 2 is 1, and 0 otherwise.
- R7: With bit 7 = 0 and bit 2 = 0, precomp is 1 when bit 4 = 0 and 0 when bit 4 = 1, for any track.
- R8: With bit 7 = 0 and bit 2 = 1, precomp is 1 on every track when bit 4 = 0. When bit 4 = 1, precomp is 1 only for track numbers 44 through 76 inclusive.
- R9: single_den equals bit 7, and precomp is 0 whenever bit 7 = 1.
- R10: With bit 6 = 1, ready drops in the cycle a new data-register access begins (dreg_sel with rd or wr, absent in the prior cycle). Ready stays low until data request is 1 and is high in that same cycle.
- R11: A data request present in the first cycle of an access prevents any wait. After release, ready stays high for the rest of that access.
- R12: With bit 6 = 0, data-register accesses never lower ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| bus_addr | input | 3 | Low I/O address bits |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wdata | input | 8 | Write data byte |
| dreg_sel | input | 1 | Decode of the controller data register |
| fdc_drq | input | 1 | Controller data request |
| track | input | 8 | Current track number |
| drv_sel | output | 4 | One-hot drive select |
| media_8in | output | 1 | Media size select |
| ctl_8in_mode | output | 1 | Controller 8-inch timing mode |
| single_den | output | 1 | Single density select |
| precomp | output | 1 | Write precompensation enable |
| bus_rdy | output | 1 | Bus ready, low holds the CPU |

## Verification
Two things can land in the same cycle: the first cycle of a data-register access and the controller's data request. The bench raises both strobes and data request together on one falling clock edge, with waits armed. It then checks that ready never dips, either right away or after the next edge. A second case presents data request only after two stalled cycles. The bench judges that ready reads low in each stalled cycle and rises in the same sampling window as the request, rather than one edge later.

// File: rtl/fdc_ifctl_pkg.sv
package fdc_ifctl_pkg;

  localparam int TRK_W = 8;

  typedef struct packed {
    logic sden;     // bit 7
    logic wait_en;  // bit 6
    logic fast;     // bit 5
    logic pc_sel;   // bit 4
    logic drv_en;   // bit 3
    logic media8;   // bit 2
    logic ds_b;     // bit 1
    logic ds_a;     // bit 0
  } ctrl_t;

  // Drive index: bit0 is the high weight, bit1 the low weight.
  function automatic logic [1:0] f_drive_idx(ctrl_t c);
    return {c.ds_a, c.ds_b};
  endfunction

  function automatic logic f_in_band(logic [TRK_W-1:0] trk,
                                     logic [TRK_W-1:0] lo,
                                     logic [TRK_W-1:0] hi);
    return (trk >= lo) && (trk <= hi);
  endfunction

  function automatic logic f_precomp(ctrl_t c, logic [TRK_W-1:0] trk,
                                     logic [TRK_W-1:0] lo,
                                     logic [TRK_W-1:0] hi);
    logic r;
    if (c.sden)         r = 1'b0;
    else if (!c.pc_sel) r = 1'b1;
    else if (c.media8)  r = f_in_band(trk, lo, hi);
    else                r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/fdc_ctl_latch.sv
module fdc_ctl_latch
  import fdc_ifctl_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output ctrl_t             ctrl,
  output logic              load_evt
);

  logic       wr_en;
  logic       wr_en_q;
  logic [7:0] data_q;

  assign wr_en    = bus_wr && (bus_addr == PORT_ADDR);
  assign load_evt = wr_en_q && !wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q <= 1'b0;
      data_q  <= '0;
      ctrl    <= '0;
    end else begin
      wr_en_q <= wr_en;
      if (wr_en)    data_q <= bus_wdata;
      if (load_evt) ctrl   <= ctrl_t'(data_q);
    end
  end

  // R1: register only changes on the trailing edge of the port enable
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(ctrl));

  // R1: byte committed is the one held while the enable was high
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en_q && !wr_en) |=> (ctrl == $past(data_q)));

endmodule

// File: rtl/fdc_sel_decode.sv
module fdc_sel_decode
  import fdc_ifctl_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int PC_LO   = 44,
  parameter int PC_HI   = 76
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [TRK_W-1:0]  track,
  output logic [NUM_DRV-1:0] drv_sel,
  output logic              media_8in,
  output logic              ctl_8in_mode,
  output logic              single_den,
  output logic              precomp
);

  localparam int SEL_W = $clog2(NUM_DRV);
  localparam logic [TRK_W-1:0] LO_T = TRK_W'(PC_LO);
  localparam logic [TRK_W-1:0] HI_T = TRK_W'(PC_HI);

  logic [SEL_W-1:0] drv_idx;
  assign drv_idx = SEL_W'(f_drive_idx(ctrl));

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
    assign drv_sel[i] = ctrl.drv_en && (drv_idx == SEL_W'(i));
  end

  assign media_8in    = ctrl.media8;
  assign ctl_8in_mode = ctrl.fast || ctrl.media8;
  assign single_den   = ctrl.sden;
  assign precomp      = f_precomp(ctrl, track, LO_T, HI_T);

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(drv_sel));

  p_off_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl.drv_en |-> (drv_sel == '0));

  p_sden_r9: assert property (@(posedge clk) disable iff (rst)
    single_den |-> !precomp);

  p_mode_r6: assert property (@(posedge clk) disable iff (rst)
    media_8in |-> ctl_8in_mode);

endmodule

// File: rtl/fdc_wait_ctl.sv
module fdc_wait_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wait_en,
  input  logic dreg_sel,
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic fdc_drq,
  output logic bus_rdy,
  output logic acc_start
);

  logic access;
  logic access_q;
  logic waiting;
  logic hold;

  assign access    = dreg_sel && (bus_rd || bus_wr);
  assign acc_start = access && !access_q;
  assign hold      = ((acc_start && wait_en) || waiting) && !fdc_drq;
  assign bus_rdy   = !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      access_q <= 1'b0;
      waiting  <= 1'b0;
    end else begin
      access_q <= access;
      waiting  <= hold;
    end
  end

  // R10: data request always releases ready in the same cycle
  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    fdc_drq |-> bus_rdy);

  // R10: once held, ready stays low until data request arrives
  p_persist_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rdy |=> (!bus_rdy || fdc_drq));

  // R11: a wait only opens at the first cycle of an access
  p_start_r11: assert property (@(posedge clk) disable iff (rst)
    (!bus_rdy && !$past(!bus_rdy)) |-> acc_start);

endmodule

// File: rtl/fdc_ifctl.sv
module fdc_ifctl
  import fdc_ifctl_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_DRV = 4,
  parameter int PC_LO   = 44,
  parameter int PC_HI   = 76
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  input  logic               dreg_sel,
  input  logic               fdc_drq,
  input  logic [TRK_W-1:0]   track,
  output logic [NUM_DRV-1:0] drv_sel,
  output logic               media_8in,
  output logic               ctl_8in_mode,
  output logic               single_den,
  output logic               precomp,
  output logic               bus_rdy
);

  ctrl_t ctrl;
  logic  load_evt;
  logic  acc_start;

  fdc_ctl_latch #(.ADDR_W(ADDR_W), .PORT_ADDR(ADDR_W'(3'b101))) u_latch (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ctrl(ctrl), .load_evt(load_evt)
  );

  fdc_sel_decode #(.NUM_DRV(NUM_DRV), .PC_LO(PC_LO), .PC_HI(PC_HI)) u_dec (
    .clk(clk), .rst(rst), .ctrl(ctrl), .track(track), .drv_sel(drv_sel),
    .media_8in(media_8in), .ctl_8in_mode(ctl_8in_mode),
    .single_den(single_den), .precomp(precomp)
  );

  fdc_wait_ctl u_wait (
    .clk(clk), .rst(rst), .wait_en(ctrl.wait_en), .dreg_sel(dreg_sel),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .fdc_drq(fdc_drq),
    .bus_rdy(bus_rdy), .acc_start(acc_start)
  );

  // R2: after reset nothing is selected and the bus runs free
  p_reset_r2: assert property (@(posedge clk)
    $past(rst) && rst |-> (drv_sel == '0) && bus_rdy);

  // R12: with waits disarmed and none pending, an access start never stalls
  p_nowait_r12: assert property (@(posedge clk) disable iff (rst)
    (acc_start && !ctrl.wait_en && $past(bus_rdy)) |-> bus_rdy);

endmodule

// File: tb/sim_fdc_ifctl.sv
`timescale 1ns/1ps
module sim_fdc_ifctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, dreg_sel = 1'b0, fdc_drq = 1'b0;
  logic [7:0] bus_wdata = '0, track = '0;
  logic [3:0] drv_sel;
  logic       media_8in, ctl_8in_mode, single_den, precomp, bus_rdy;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  fdc_ifctl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .dreg_sel(dreg_sel),
    .fdc_drq(fdc_drq), .track(track), .drv_sel(drv_sel),
    .media_8in(media_8in), .ctl_8in_mode(ctl_8in_mode),
    .single_den(single_den), .precomp(precomp), .bus_rdy(bus_rdy)
  );

  // {ctrl, track, expected {sel[3:0], media, mode, sden, pc}}
  localparam logic [23:0] VEC [14] = '{
    {8'h08, 8'd0,  8'h11}, {8'h0A, 8'd0,  8'h21}, {8'h09, 8'd0,  8'h41},
    {8'h0B, 8'd0,  8'h81}, {8'h03, 8'd0,  8'h01}, {8'h10, 8'd50, 8'h00},
    {8'h14, 8'd43, 8'h0C}, {8'h14, 8'd44, 8'h0D}, {8'h14, 8'd76, 8'h0D},
    {8'h14, 8'd77, 8'h0C}, {8'h20, 8'd9,  8'h05}, {8'h80, 8'd0,  8'h02},
    {8'h94, 8'd60, 8'h0E}, {8'h04, 8'd5,  8'h0D}
  };

  function automatic logic [7:0] outs();
    return {drv_sel, media_8in, ctl_8in_mode, single_den, precomp};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic port_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 outputs", outs(), 8'h01);
    check("R2 ready", {7'd0, bus_rdy}, 8'h01);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      track = VEC[i][15:8];
      port_write(3'b101, VEC[i][23:16]);
      #1 check("R3 R4 R5 R6 R7 R8 R9 vector", outs(), VEC[i][7:0]);
    end

    // R1: wrong address ignored
    port_write(3'b101, 8'h08);
    port_write(3'b100, 8'h0B);
    check("R1 wrong addr", outs(), 8'h11);
    port_write(3'b111, 8'h0B);
    check("R1 wrong addr 111", outs(), 8'h11);
    // R1: no change while strobe still high
    @(negedge clk); bus_addr = 3'b101; bus_wdata = 8'h0B; bus_wr = 1'b1;
    @(negedge clk);
    check("R1 strobe high", outs(), 8'h11);
    bus_wr = 1'b0;
    @(negedge clk);
    check("R1 trailing edge", outs(), 8'h81);

    // R12: waits disabled
    port_write(3'b101, 8'h08);
    @(negedge clk); dreg_sel = 1'b1; bus_rd = 1'b1;
    #1 check("R12 no wait start", {7'd0, bus_rdy}, 8'h01);
    @(negedge clk);
    check("R12 no wait later", {7'd0, bus_rdy}, 8'h01);
    dreg_sel = 1'b0; bus_rd = 1'b0;

    // R10: waits armed, request after two stalled cycles
    port_write(3'b101, 8'h48);
    @(negedge clk); dreg_sel = 1'b1; bus_wr = 1'b1;
    #1 check("R10 stall first", {7'd0, bus_rdy}, 8'h00);
    @(negedge clk);
    check("R10 stall second", {7'd0, bus_rdy}, 8'h00);
    fdc_drq = 1'b1;
    #1 check("R10 release same cycle", {7'd0, bus_rdy}, 8'h01);
    @(negedge clk); fdc_drq = 1'b0;
    #1 check("R11 no rearm same access", {7'd0, bus_rdy}, 8'h01);
    @(negedge clk);
    check("R11 still ready", {7'd0, bus_rdy}, 8'h01);
    dreg_sel = 1'b0; bus_wr = 1'b0;

    // R11: request in same cycle as access start
    @(negedge clk); dreg_sel = 1'b1; bus_rd = 1'b1; fdc_drq = 1'b1;
    #1 check("R11 coincident request", {7'd0, bus_rdy}, 8'h01);
    @(negedge clk); fdc_drq = 1'b0;
    #1 check("R11 coincident after edge", {7'd0, bus_rdy}, 8'h01);
    dreg_sel = 1'b0; bus_rd = 1'b0;

    // R2: reset mid-wait releases ready and clears register
    @(negedge clk); dreg_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); dreg_sel = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    check("R2 reset clears", outs(), 8'h01);
    check("R2 reset ready", {7'd0, bus_rdy}, 8'h01);

    finish_run();
  end

endmodule